// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming Ethernet frame is kept or dropped, based only on its 48-bit destination address. The receive path presents the destination address as six bytes, one per cycle on a byte strobe, starting with the octet sent first on the wire. Once the sixth byte has arrived, the filter sorts the address into one of three classes: broadcast, multicast or unicast. It then applies the mode controls and reports a single-cycle decision.

Four level inputs set the mode. Promiscuous mode accepts everything. Broadcast reception and exact station-address matching can each be switched off on their own. Group (multicast) frames are either all accepted or all rejected, under a single accept-all-multicast control. The station address is a 48-bit input that the surrounding logic holds stable. A frame-start pulse begins a fresh address, which lets a truncated or aborted header be thrown away.

Top module: `rx_da_filter`

## Requirements
- R1: The first byte received after frame start goes to address bits [47:40], and the sixth byte goes to bits [7:0]. `done` is high for exactly one cycle, in the cycle after the cycle in which the sixth byte is presented with `byte_valid`.
- R2: With `promisc` = 1, every frame is accepted whatever its destination address.
- R3: The broadcast address (all 48 bits one) is accepted when `no_bcast` = 0.
- R4: With `no_bcast` = 1 and `promisc` = 0, broadcast frames are rejected.
- R5: A unicast address (bit 40, the least significant bit of the first byte, equal to 0) is accepted when it equals `station_addr` and `no_ucast` = 0. It is rejected when it differs from `station_addr` and `promisc` = 0.
- R6: With `no_ucast` = 1 and `promisc` = 0, a unicast frame that matches `station_addr` is rejected.
- R7: An address with bit 40 = 1 that is not broadcast is accepted exactly when `all_mcast` = 1 (or `promisc` = 1).
- R8: `frame_start` discards any address bytes already collected. A byte presented in the same cycle as `frame_start` is taken as the first byte of the new address.
- R9: After the sixth byte, further bytes are ignored and produce no further `done` until the next `frame_start`.
- R10: After reset, `done` and `accept` are 0, and no partial address is held.
- R11: The mode inputs and `station_addr` are sampled in the cycle of the sixth byte. Their values in earlier byte cycles have no effect.
- R12: `accept` is 0 in every cycle in which `done` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Begins a new destination address |
| byte_valid | input | 1 | `byte_data` carries an address byte this cycle |
| byte_data | input | 8 | Address byte, first byte on the wire first |
| station_addr | input | 48 | Programmed station address, first byte in [47:40] |
| promisc | input | 1 | Accept every frame |
| no_bcast | input | 1 | Reject broadcast frames |
| no_ucast | input | 1 | Disable exact station-address matching |
| all_mcast | input | 1 | Accept every non-broadcast multicast frame |
| done | output | 1 | One-cycle pulse: decision valid |
| accept | output | 1 | Frame accepted; meaningful only while `done` is 1 |

## Verification
A byte counter that has drifted shows up within one frame. Either `done` fires one cycle early or late compared with the sixth byte, or a seventh byte raises a second `done`. Both are caught on the very next cycle. A byte placed in the wrong slot of the address register changes the class or the match result. That shows up as a wrong `accept` in the same `done` cycle, so each decision is checked against rules applied to the address the bench sent. Stale bytes left behind after `frame_start` corrupt the next decision, and that is checked one frame later.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;

    localparam int OCTET_W = 8;
    localparam int OCTETS  = 6;
    localparam int ADDR_W  = OCTET_W * OCTETS;
    localparam int GROUP_BIT = ADDR_W - OCTET_W;

    typedef struct packed {
        logic promisc;
        logic no_bcast;
        logic no_ucast;
        logic all_mcast;
    } rx_mode_t;

    typedef enum logic [1:0] {
        DA_UCAST = 2'd0,
        DA_MCAST = 2'd1,
        DA_BCAST = 2'd2
    } da_class_t;

    function automatic da_class_t classify(input logic [ADDR_W-1:0] a);
        if (&a)
            return DA_BCAST;
        else if (a[GROUP_BIT])
            return DA_MCAST;
        else
            return DA_UCAST;
    endfunction

endpackage

// File: rtl/dafilt_collect.sv
module dafilt_collect #(
    parameter int NB = 6,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             vld,
    input  logic [BW-1:0]    din,
    output logic [NB*BW-1:0] addr_next,
    output logic [NB*BW-1:0] addr_q,
    output logic             last
);
    localparam int AW = NB * BW;
    localparam int CW = $clog2(NB + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] base_cnt;
    logic [AW-1:0] base_addr;
    logic          take;

    always_comb begin
        base_cnt  = start ? '0 : cnt;
        base_addr = start ? '0 : addr_q;
        take      = vld && (base_cnt < CW'(NB));
        addr_next = take ? {base_addr[AW-BW-1:0], din} : base_addr;
        last      = take && (base_cnt == CW'(NB - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            addr_q <= '0;
        end else begin
            cnt    <= take ? base_cnt + CW'(1) : base_cnt;
            addr_q <= addr_next;
        end
    end

    a_r9_count_bounded : assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(NB));

    a_r8_start_clears : assert property (@(posedge clk) disable iff (rst)
        (start && !vld) |=> (cnt == '0));

    a_r9_hold_when_full : assert property (@(posedge clk) disable iff (rst)
        (cnt == CW'(NB) && !start) |=> $stable(addr_q));

endmodule

// File: rtl/dafilt_decide.sv
module dafilt_decide
    import dafilt_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] station,
    input  rx_mode_t          mode,
    output logic              accept
);
    logic [OCTETS-1:0] oct_eq;
    da_class_t         cls;
    logic              exact;

    for (genvar g = 0; g < OCTETS; g++) begin : g_oct
        assign oct_eq[g] = (addr[g*OCTET_W +: OCTET_W] == station[g*OCTET_W +: OCTET_W]);
    end

    always_comb begin
        cls   = classify(addr);
        exact = (&oct_eq) && !mode.no_ucast;
        if (mode.promisc)
            accept = 1'b1;
        else begin
            unique case (cls)
                DA_BCAST: accept = !mode.no_bcast;
                DA_MCAST: accept = mode.all_mcast;
                default:  accept = exact;
            endcase
        end
    end

endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
    import dafilt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic [47:0]       station_addr,
    input  logic              promisc,
    input  logic              no_bcast,
    input  logic              no_ucast,
    input  logic              all_mcast,
    output logic              done,
    output logic              accept
);
    logic [ADDR_W-1:0] addr_next;
    logic [ADDR_W-1:0] addr_q;
    logic              last_byte;
    logic              acc_comb;
    rx_mode_t          mode;

    assign mode = '{promisc: promisc, no_bcast: no_bcast,
                    no_ucast: no_ucast, all_mcast: all_mcast};

    dafilt_collect #(.NB(OCTETS), .BW(OCTET_W)) u_collect (
        .clk       (clk),
        .rst       (rst),
        .start     (frame_start),
        .vld       (byte_valid),
        .din       (byte_data),
        .addr_next (addr_next),
        .addr_q    (addr_q),
        .last      (last_byte)
    );

    dafilt_decide u_decide (
        .addr    (addr_next),
        .station (station_addr),
        .mode    (mode),
        .accept  (acc_comb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done   <= 1'b0;
            accept <= 1'b0;
        end else begin
            done   <= last_byte;
            accept <= last_byte && acc_comb;
        end
    end

    a_r12_accept_needs_done : assert property (@(posedge clk) disable iff (rst)
        !done |-> !accept);

    a_r1_done_single : assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r1_done_after_byte : assert property (@(posedge clk) disable iff (rst)
        done |-> $past(byte_valid));

    a_r2_promisc_accepts : assert property (@(posedge clk) disable iff (rst)
        (done && $past(promisc)) |-> accept);

    a_r4_bcast_blocked : assert property (@(posedge clk) disable iff (rst)
        (done && (&addr_q) && $past(no_bcast) && !$past(promisc)) |-> !accept);

    a_r6_exact_disabled : assert property (@(posedge clk) disable iff (rst)
        (done && !addr_q[GROUP_BIT] && $past(no_ucast) && !$past(promisc)) |-> !accept);

    a_r7_mcast_gate : assert property (@(posedge clk) disable iff (rst)
        (done && addr_q[GROUP_BIT] && !(&addr_q) && !$past(promisc))
            |-> (accept == $past(all_mcast)));

endmodule

// File: tb/tb_rx_da_filter.sv
module tb_rx_da_filter;

    localparam logic [47:0] STA   = 48'h02_11_22_33_44_55;
    localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;
    localparam logic [47:0] MCAST = 48'h01_00_5E_00_00_01;
    localparam logic [47:0] OTHER = 48'h02_11_22_33_44_54;
    localparam int NV = 14;

    // {addr, promisc, no_bcast, no_ucast, all_mcast, expected accept}
    localparam logic [52:0] VEC [NV] = '{
        {STA,   5'b0000_1},  // R5 exact match
        {OTHER, 5'b0000_0},  // R5 mismatch
        {STA,   5'b0010_0},  // R6 exact path disabled
        {STA,   5'b1010_1},  // R2 promisc overrides
        {BCAST, 5'b0000_1},  // R3 broadcast default
        {BCAST, 5'b0100_0},  // R4 broadcast disabled
        {BCAST, 5'b1100_1},  // R2/R4 promisc wins
        {MCAST, 5'b0000_0},  // R7 multicast off
        {MCAST, 5'b0001_1},  // R7 multicast on
        {MCAST, 5'b1000_1},  // R2 promisc multicast
        {OTHER, 5'b1000_1},  // R2 promisc mismatch
        {BCAST, 5'b0101_0},  // R4 all_mcast does not admit broadcast
        {STA,   5'b0001_1},  // R5 all_mcast no effect on unicast
        {OTHER, 5'b0101_0}   // R5 mismatch with other modes
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        frame_start;
    logic        byte_valid;
    logic [7:0]  byte_data;
    logic [47:0] station_addr;
    logic        promisc, no_bcast, no_ucast, all_mcast;
    logic        done, accept;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rx_da_filter dut (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .station_addr(station_addr), .promisc(promisc),
        .no_bcast(no_bcast), .no_ucast(no_ucast), .all_mcast(all_mcast),
        .done(done), .accept(accept)
    );

    task automatic check(input string req, input logic got_d, input logic got_a,
                         input logic exp_d, input logic exp_a);
        checks++;
        if (got_d !== exp_d || got_a !== exp_a) begin
            errors++;
            $display("FAIL %s: done/accept = %b/%b, expected %b/%b",
                     req, got_d, got_a, exp_d, exp_a);
        end
    endtask

    task automatic set_mode(input logic [3:0] m);
        {promisc, no_bcast, no_ucast, all_mcast} = m;
    endtask

    // Sends n bytes of addr (first at [47:40]); optional frame_start with byte 0.
    task automatic send(input logic [47:0] a, input int n, input bit with_start);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_start = with_start && (i == 0);
            byte_valid  = 1'b1;
            byte_data   = a[47-8*i -: 8];
        end
        @(negedge clk);
        frame_start = 1'b0;
        byte_valid  = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        frame_start = 1'b1;
        byte_valid  = 1'b0;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, got running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; frame_start = 1'b0; byte_valid = 1'b0; byte_data = '0;
        station_addr = STA; set_mode(4'b0000);
        repeat (3) @(negedge clk);
        check("R10 reset", done, accept, 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R10 after reset", done, accept, 1'b0, 1'b0);

        // Vector table, R1 timing checked on each entry
        for (int v = 0; v < NV; v++) begin
            set_mode(VEC[v][4:1]);
            pulse_start();
            send(VEC[v][52:5], 6, 1'b0);
            check($sformatf("R1 vector %0d decision", v), done, accept, 1'b1, VEC[v][0]);
            @(negedge clk);
            check($sformatf("R12 vector %0d idle", v), done, accept, 1'b0, 1'b0);
        end

        // R1: byte order, reversed station address must not match
        set_mode(4'b0000);
        pulse_start();
        send(48'h55_44_33_22_11_02, 6, 1'b0);
        check("R1 byte order", done, accept, 1'b1, 1'b0);

        // R1: no done after five bytes
        pulse_start();
        send(STA, 5, 1'b0);
        check("R1 no early done", done, accept, 1'b0, 1'b0);

        // R8: partial bytes discarded by frame_start
        pulse_start();
        send(STA, 6, 1'b0);
        check("R8 after partial", done, accept, 1'b1, 1'b1);

        // R8: frame_start in same cycle as first byte, after junk
        pulse_start();
        send(48'hAA_BB_CC_00_00_00, 3, 1'b0);
        send(STA, 6, 1'b1);
        check("R8 start with byte", done, accept, 1'b1, 1'b1);

        // R9: extra bytes ignored
        @(negedge clk);
        send(BCAST, 6, 1'b0);
        check("R9 no second done", done, accept, 1'b0, 1'b0);
        @(negedge clk);
        check("R9 still idle", done, accept, 1'b0, 1'b0);

        // R11: promisc during early bytes only
        pulse_start();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            promisc    = (i < 5);
            byte_valid = 1'b1;
            byte_data  = OTHER[47-8*i -: 8];
        end
        @(negedge clk);
        byte_valid = 1'b0;
        promisc    = 1'b1;
        check("R11 late mode sampled", done, accept, 1'b1, 1'b0);

        // R11: no_bcast set only in sixth byte cycle
        promisc = 1'b0;
        pulse_start();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            no_bcast   = (i == 5);
            byte_valid = 1'b1;
            byte_data  = 8'hFF;
        end
        @(negedge clk);
        byte_valid = 1'b0;
        no_bcast   = 1'b0;
        check("R11 R4 last-cycle disable", done, accept, 1'b1, 1'b0);

        // R10: reset mid-address discards collected bytes
        pulse_start();
        send(48'h11_22_33_00_00_00, 3, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        send(STA, 6, 1'b0);
        check("R10 reset clears partial", done, accept, 1'b1, 1'b1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule